// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a short supply of instruction bytes ready for an execution stage. A fetch side reads 16-bit words of code memory at a running prefetch address and pushes their bytes into a small first-in, first-out store. The execution side then takes one byte at a time. Fetching runs ahead of demand: a new word is requested whenever enough slots are free, so memory reads overlap with the consumption of bytes fetched earlier.

When the program changes flow, the execution side raises a flush with the new target address. The flush empties the store in a single cycle and restarts fetching at the target. A word read that is still outstanding when the flush arrives is allowed to finish on the bus, but its data is thrown away.

The fetch port uses a plain request/acknowledge handshake. The request and its address stay asserted until the acknowledge, and the word is taken in the cycle the acknowledge is high. Bytes are stored little-endian: `fetch_data_i[7:0]` belongs to the even address and `fetch_data_i[15:8]` to the odd address that follows it.

Top module: `prefetch_queue`

## Requirements
- R1: While `rst` is high, `fetch_req_o` and `byte_valid_o` are low. At the first rising edge after `rst` falls, `fetch_req_o` goes high with `fetch_addr_o` equal to `RESET_ADDR`.
- R2: The store holds at most `DEPTH` (default 6) bytes. A word request for an even address is raised only when at least two slots are free, so with no pops the store fills to exactly six bytes and the request then stays low.
- R3: Bytes leave in fetch order. For an even request address, `fetch_data_i[7:0]` is delivered first and `fetch_data_i[15:8]` second, and the prefetch address advances by 2.
- R4: For an odd request address only `fetch_data_i[15:8]` is stored, one free slot is enough to raise the request, and the prefetch address advances by 1.
- R5: Once raised, `fetch_req_o` stays high with `fetch_addr_o` unchanged until a cycle in which `fetch_ack_i` is high.
- R6: Fetching and consumption overlap: a request can be pending while `byte_valid_o` is high and bytes are being popped.
- R7: After a cycle with `flush_i` high, `byte_valid_o` is low, every stored byte is gone, and the next request uses `flush_addr_i`.
- R8: If a request is outstanding when `flush_i` is high, the data acknowledged for it, whether in that cycle or later, is discarded.
- R9: `byte_valid_o` is low while the store is empty, and a `pop_i` in that state has no effect.
- R10: A push and a pop in the same cycle leave the byte count exact, so no byte is lost or repeated during continuous streaming.
- R11: When `flush_i` and `pop_i` are high in the same cycle, the flush takes effect and the pop is ignored.
- R12: While `byte_valid_o` is high and no pop or flush occurs, `byte_valid_o` and `byte_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush_i | input | 1 | Discard queued bytes and restart at a new address |
| flush_addr_i | input | ADDR_W | Restart address, used when `flush_i` is high |
| fetch_req_o | output | 1 | Word fetch request |
| fetch_addr_o | output | ADDR_W | Byte address of the requested fetch |
| fetch_ack_i | input | 1 | Fetch data valid, completes the request |
| fetch_data_i | input | 16 | Fetched word, little-endian |
| byte_valid_o | output | 1 | At least one byte is queued |
| byte_o | output | 8 | Oldest queued byte |
| pop_i | input | 1 | Consume the byte on `byte_o` |

## Verification
A flush or a pop at one rising edge shows on `byte_valid_o` and `byte_o` right after that edge. An acknowledged word is visible after the edge that takes it. A new request appears one edge after the slots it needs are free, and never in the same edge as an acknowledge. Because of this, the bench drives every input at the falling edge and reads the outputs at a falling edge. The stimulus sits half a cycle before the edge it acts on, and each result is read half a cycle after the edge that produces it. Checks on byte order wait, with a bound, for `byte_valid_o` and then compare against bytes computed from the address. Checks on an exact cycle, such as the request after the slots free up or the empty store after a flush, are read at the stated falling edge.

// File: rtl/pq_pkg.sv
package pq_pkg;
  // How many bytes enter the store in a cycle
  typedef enum logic [1:0] {
    PUSH_NONE = 2'd0,
    PUSH_ONE  = 2'd1,
    PUSH_TWO  = 2'd2
  } push_e;
endpackage

// File: rtl/pq_fetch_ctrl.sv
module pq_fetch_ctrl
  import pq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DEPTH      = 6,
  parameter int          CW         = $clog2(DEPTH + 1),
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic [CW-1:0]     occ_i,
  input  logic              fetch_ack_i,
  input  logic [15:0]       fetch_data_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output push_e             push_o,
  output logic [7:0]        push_b0_o,
  output logic [7:0]        push_b1_o
);
  logic [ADDR_W-1:0] pf_addr;
  logic              stale;
  logic [CW-1:0]     free_slots;
  logic [CW-1:0]     need_slots;
  logic              take;

  assign free_slots = CW'(DEPTH) - occ_i;
  assign need_slots = pf_addr[0] ? CW'(1) : CW'(2);
  assign take       = fetch_req_o && fetch_ack_i && !stale && !flush_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_addr      <= RESET_ADDR;
      fetch_req_o  <= 1'b0;
      fetch_addr_o <= '0;
      stale        <= 1'b0;
    end else begin
      if (fetch_req_o && fetch_ack_i) begin
        fetch_req_o <= 1'b0;
        stale       <= 1'b0;
        if (take)
          pf_addr <= fetch_addr_o + (fetch_addr_o[0] ? ADDR_W'(1) : ADDR_W'(2));
      end else if (fetch_req_o && flush_i) begin
        stale <= 1'b1;
      end else if (!fetch_req_o && !flush_i && free_slots >= need_slots) begin
        fetch_req_o  <= 1'b1;
        fetch_addr_o <= pf_addr;
      end
      if (flush_i)
        pf_addr <= flush_addr_i;
    end
  end

  always_comb begin
    push_o    = PUSH_NONE;
    push_b0_o = fetch_addr_o[0] ? fetch_data_i[15:8] : fetch_data_i[7:0];
    push_b1_o = fetch_data_i[15:8];
    if (take)
      push_o = fetch_addr_o[0] ? PUSH_ONE : PUSH_TWO;
  end
endmodule

// File: rtl/pq_storage.sv
module pq_storage
  import pq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush_i,
  input  push_e         push_i,
  input  logic [7:0]    push_b0_i,
  input  logic [7:0]    push_b1_i,
  input  logic          pop_i,
  output logic [7:0]    rd_data_o,
  output logic          valid_o,
  output logic [CW-1:0] occ_o
);
  logic [7:0]    slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_ptr1;
  logic          we0, we1, pop_ok;
  logic [CW-1:0] n_push, occ_nxt;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign we0     = (push_i != PUSH_NONE);
  assign we1     = (push_i == PUSH_TWO);
  assign n_push  = we1 ? CW'(2) : (we0 ? CW'(1) : CW'(0));
  assign pop_ok  = pop_i && valid_o && !flush_i;
  assign wr_ptr1 = step(wr_ptr);
  assign occ_nxt = flush_i ? '0 : occ_o + n_push - CW'(pop_ok);

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we0 && wr_ptr == PW'(i))
        slot[i] <= push_b0_i;
      else if (we1 && wr_ptr1 == PW'(i))
        slot[i] <= push_b1_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      occ_o   <= occ_nxt;
      valid_o <= (occ_nxt != '0);
      if (flush_i) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (we1)
          wr_ptr <= step(wr_ptr1);
        else if (we0)
          wr_ptr <= wr_ptr1;
        if (pop_ok)
          rd_ptr <= step(rd_ptr);
      end
    end
  end

  assign rd_data_o = slot[rd_ptr];
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          DEPTH      = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_ack_i,
  input  logic [15:0]       fetch_data_i,
  output logic              byte_valid_o,
  output logic [7:0]        byte_o,
  input  logic              pop_i
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);

  logic [CW-1:0] occ;
  push_e         push;
  logic [7:0]    push_b0, push_b1;

  pq_fetch_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .CW(CW), .RESET_ADDR(RESET_ADDR)
  ) u_ctrl (
    .clk(clk), .rst(rst), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .occ_i(occ), .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .push_o(push), .push_b0_o(push_b0), .push_b1_o(push_b1)
  );

  pq_storage #(
    .DEPTH(DEPTH), .CW(CW), .PW(PW)
  ) u_store (
    .clk(clk), .rst(rst), .flush_i(flush_i), .push_i(push),
    .push_b0_i(push_b0), .push_b1_i(push_b1), .pop_i(pop_i),
    .rd_data_o(byte_o), .valid_o(byte_valid_o), .occ_o(occ)
  );
endmodule

// File: rtl/pq_checker.sv
module pq_checker #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 6,
  parameter int CW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              flush_i,
  input logic              pop_i,
  input logic              fetch_req_o,
  input logic              fetch_ack_i,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              byte_valid_o,
  input logic [7:0]        byte_o,
  input logic [CW-1:0]     occ
);
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  // R2
  free_slots_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fetch_req_o) |-> (CW'(DEPTH) - occ) >= (fetch_addr_o[0] ? CW'(1) : CW'(2)));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req_o && !fetch_ack_i |=> fetch_req_o && $stable(fetch_addr_o));

  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !byte_valid_o && occ == '0);

  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    !byte_valid_o && pop_i && !flush_i && !(fetch_req_o && fetch_ack_i) |=> !byte_valid_o);

  // R12
  hold_byte_chk: assert property (@(posedge clk) disable iff (rst)
    byte_valid_o && !pop_i && !flush_i |=> byte_valid_o && $stable(byte_o));
endmodule

bind prefetch_queue pq_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .CW(CW)) u_pq_checker (
  .clk(clk), .rst(rst), .flush_i(flush_i), .pop_i(pop_i),
  .fetch_req_o(fetch_req_o), .fetch_ack_i(fetch_ack_i), .fetch_addr_o(fetch_addr_o),
  .byte_valid_o(byte_valid_o), .byte_o(byte_o), .occ(occ)
);

// File: tb/test_prefetch_queue.sv
`timescale 1ns/1ps
module test_prefetch_queue;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush_i = 1'b0;
  logic [AW-1:0] flush_addr_i = '0;
  logic          fetch_req_o;
  logic [AW-1:0] fetch_addr_o;
  logic          fetch_ack_i = 1'b0;
  logic [15:0]   fetch_data_i = '0;
  logic          byte_valid_o;
  logic [7:0]    byte_o;
  logic          pop_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit mem_on = 1'b0;
  int mem_lat = 0;
  int wait_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prefetch_queue #(.ADDR_W(AW), .DEPTH(6), .RESET_ADDR(16'h0000)) i_prefetch_queue (
    .clk(clk), .rst(rst), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .fetch_req_o(fetch_req_o), .fetch_addr_o(fetch_addr_o),
    .fetch_ack_i(fetch_ack_i), .fetch_data_i(fetch_data_i),
    .byte_valid_o(byte_valid_o), .byte_o(byte_o), .pop_i(pop_i)
  );

  function automatic logic [7:0] code_byte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  function automatic logic [15:0] code_word(input logic [AW-1:0] a);
    logic [AW-1:0] e;
    e = {a[AW-1:1], 1'b0};
    return {code_byte(e | AW'(1)), code_byte(e)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: answers a request after mem_lat waiting cycles
  initial begin
    forever begin
      @(negedge clk);
      fetch_ack_i = 1'b0;
      if (mem_on && fetch_req_o) begin
        if (wait_cnt >= mem_lat) begin
          fetch_ack_i  = 1'b1;
          fetch_data_i = code_word(fetch_addr_o);
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end else begin
        wait_cnt = 0;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000 && !done) begin
        fails++;
        $display("FAIL watchdog (all requirements): actual=%0d cycles expected below 20000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic get_byte(input string req, input logic [7:0] exp);
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      if (byte_valid_o) begin
        check(req, byte_o, exp);
        pop_i = 1'b1;
        @(posedge clk);
        #1 pop_i = 1'b0;
        return;
      end
    end
    check({req, " byte never valid"}, 0, 1);
  endtask

  task automatic do_flush(input logic [AW-1:0] target, input bit with_pop);
    @(negedge clk);
    flush_i = 1'b1;
    flush_addr_i = target;
    pop_i = with_pop;
    @(posedge clk);
    #1 flush_i = 1'b0;
    pop_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    check("R1 req in reset", fetch_req_o, 0);
    check("R1 valid in reset", byte_valid_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 req after reset", fetch_req_o, 1);
    check("R1 addr after reset", fetch_addr_o, 16'h0000);
  endtask

  task automatic t_fill();
    mem_on = 1'b1; mem_lat = 0;
    idle(12);
    check("R2 no request when full", fetch_req_o, 0);
    check("R2 valid when full", byte_valid_o, 1);
    mem_on = 1'b0;
    for (int i = 0; i < 6; i++) get_byte("R3 order after fill", code_byte(AW'(i)));
    @(negedge clk);
    check("R2 empty after six pops", byte_valid_o, 0);
  endtask

  task automatic t_empty_pop();
    mem_on = 1'b0;
    do_flush(16'h0080, 1'b0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      pop_i = 1'b1;
    end
    @(negedge clk);
    pop_i = 1'b0;
    check("R9 valid low while empty", byte_valid_o, 0);
    mem_on = 1'b1;
    get_byte("R9 first byte after empty pops", code_byte(16'h0080));
    get_byte("R9 second byte after empty pops", code_byte(16'h0081));
  endtask

  task automatic t_odd();
    mem_on = 1'b1; mem_lat = 0;
    do_flush(16'h0101, 1'b0);
    idle(15);
    check("R4 stalls at five bytes", fetch_req_o, 0);
    mem_on = 1'b0;
    get_byte("R4 odd start byte", code_byte(16'h0101));
    idle(3);
    check("R2 request after two free", fetch_req_o, 1);
    check("R2 request address", fetch_addr_o, 16'h0106);
    mem_on = 1'b1;
    for (int i = 2; i < 9; i++) get_byte("R4 sequence after odd start", code_byte(AW'(16'h0100 + i)));
  endtask

  task automatic t_stream();
    bit overlap = 1'b0;
    mem_on = 1'b1; mem_lat = 0;
    do_flush(16'h0500, 1'b0);
    for (int i = 0; i < 24; i++) begin
      get_byte("R10 streaming order", code_byte(AW'(16'h0500 + i)));
      if (fetch_req_o && byte_valid_o) overlap = 1'b1;
    end
    check("R6 fetch overlaps consumption", overlap, 1);
    idle(12);
    mem_on = 1'b0;
    for (int i = 24; i < 30; i++) get_byte("R10 count after streaming", code_byte(AW'(16'h0500 + i)));
    @(negedge clk);
    check("R10 exactly six left", byte_valid_o, 0);
  endtask

  task automatic t_flush_full();
    mem_on = 1'b1; mem_lat = 0;
    idle(12);
    check("R7 full before flush", byte_valid_o, 1);
    do_flush(16'h0200, 1'b0);
    @(negedge clk);
    check("R7 empty after flush", byte_valid_o, 0);
    get_byte("R7 target byte", code_byte(16'h0200));
    get_byte("R7 target next", code_byte(16'h0201));
  endtask

  task automatic t_stale();
    mem_on = 1'b0;
    do_flush(16'h0040, 1'b0);
    idle(2);
    check("R5 pending request", fetch_req_o, 1);
    mem_lat = 3; mem_on = 1'b1;
    do_flush(16'h0300, 1'b0);
    @(negedge clk);
    check("R5 old address held", fetch_addr_o, 16'h0040);
    get_byte("R8 stale data dropped", code_byte(16'h0300));
    get_byte("R8 target continues", code_byte(16'h0301));
    mem_lat = 0;
  endtask

  task automatic t_flush_pop();
    mem_on = 1'b1; mem_lat = 0;
    idle(12);
    do_flush(16'h0400, 1'b1);
    @(negedge clk);
    check("R11 flush wins over pop", byte_valid_o, 0);
    get_byte("R11 first target byte", code_byte(16'h0400));
    get_byte("R11 second target byte", code_byte(16'h0401));
  endtask

  task automatic t_hold();
    mem_on = 1'b1;
    idle(12);
    mem_on = 1'b0;
    begin
      logic [7:0] first;
      first = byte_o;
      idle(4);
      check("R12 byte held", byte_o, first);
      check("R12 valid held", byte_valid_o, 1);
    end
  endtask

  initial begin
    t_reset();
    t_fill();
    t_empty_pop();
    t_odd();
    t_stream();
    t_flush_full();
    t_stale();
    t_flush_pop();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule